// File: doc/BRIEF.md
# Cross-Product FM Discriminator

This block demodulates a frequency-modulated carrier that has already been mixed down to complex baseband and lowpass filtered. Each accepted input sample carries an in-phase value I and a quadrature value Q. The block forms the first difference of each channel against the previously accepted sample. It then outputs the cross product I·ΔQ − Q·ΔI. This value is proportional to the instantaneous frequency of the rotating phasor I+jQ, scaled by the squared envelope.

The envelope of an FM signal is constant, so the block omits the division by I²+Q². No arctangent and no divider are needed, and the output is a plain multiply-subtract of the current and previous samples. The first difference acts as a two-tap derivative with taps +1 and −1.

Harmonics of the message tone appear in the output. They come from the nonlinearity of the method and are expected. Mixing, channel filtering and amplitude control happen upstream.

Top module: `fm_xprod_discrim`

## Requirements
- R1: While reset is held, and after it is released with no input accepted, `out_valid` is 0 and `out_z` is 0.
- R2: The stored previous sample is cleared by reset, so the first output after reset is 0 for any first input.
- R3: For each accepted sample n, the full-precision result is z = I[n]·(Q[n]−Q[n−1]) − Q[n]·(I[n]−I[n−1]). This is the same as Q[n]·I[n−1] − I[n]·Q[n−1]. The previous values are those of the preceding accepted sample, and all values are two's complement.
- R4: `out_valid` is high for exactly one cycle, two clock cycles after the cycle in which `in_valid` was sampled high. There is one output per accepted input.
- R5: Cycles with `in_valid` low change neither the stored previous sample nor `out_z`. `out_z` holds its value between outputs.
- R6: A counter-clockwise rotation of I+jQ (I leading Q) gives a positive output, and a clockwise rotation gives a negative one.
- R7: `out_z` is 2W+2 bits wide and does not overflow for any pair of full-scale inputs, including −2^(W−1) on every term.
- R8: `out_z` equals the full-precision result shifted arithmetically right by SHIFT bits, which rounds toward minus infinity.
- R9: Inputs may be accepted on every cycle, one sample per clock, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | In-phase sample, signed |
| in_q | input | W | Quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_z | output | 2W+2 | Discriminator output, signed |

## Verification
The bench builds two instances with W=16 and feeds them the same stream. One uses SHIFT=0 and exposes the exact 34-bit product difference, including the full-scale corners. The other uses SHIFT=4, so that floor rounding of negative results can be observed. The stimulus covers back-to-back samples, long idle gaps between samples, and rotations in both directions. This checks the output sign and the rule that history advances only on accepted samples.

// File: rtl/fm_xprod_discrim.sv
module fm_xprod_discrim #(
  parameter int W = 16,
  parameter int SHIFT = 0,
  localparam int OW = 2*W+2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_i,
  input  logic [W-1:0]  in_q,
  output logic          out_valid,
  output logic [OW-1:0] out_z
);
  localparam int DW = W+1;
  localparam int PW = 2*W+1;

  logic signed [W-1:0]  prev_i, prev_q, cur_i, cur_q;
  logic signed [DW-1:0] d_i, d_q;
  logic                 stage_v;

  logic signed [PW-1:0] p_idq, p_qdi;
  logic signed [OW-1:0] z_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_i  <= '0;
      prev_q  <= '0;
      cur_i   <= '0;
      cur_q   <= '0;
      d_i     <= '0;
      d_q     <= '0;
      stage_v <= 1'b0;
    end else begin
      stage_v <= in_valid;
      if (in_valid) begin
        cur_i  <= in_i;
        cur_q  <= in_q;
        d_i    <= DW'($signed(in_i)) - DW'(prev_i);
        d_q    <= DW'($signed(in_q)) - DW'(prev_q);
        prev_i <= in_i;
        prev_q <= in_q;
      end
    end
  end

  assign p_idq  = PW'(cur_i) * PW'(d_q);
  assign p_qdi  = PW'(cur_q) * PW'(d_i);
  assign z_full = OW'(p_idq) - OW'(p_qdi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_z     <= '0;
    end else begin
      out_valid <= stage_v;
      if (stage_v) out_z <= z_full >>> SHIFT;
    end
  end
endmodule

module fm_xprod_discrim_chk #(
  parameter int W = 16,
  parameter int OW = 2*W+2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_z
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (in_valid) seen <= 1'b1;
  end

  a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_z));
  a_r2_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !seen) |-> ##2 (out_z == '0));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_z == '0));
endmodule

bind fm_xprod_discrim fm_xprod_discrim_chk #(.W(W), .OW(OW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_z(out_z)
);

// File: tb/fm_xprod_discrim_test.sv
module fm_xprod_discrim_test;
  localparam int W = 16;
  localparam int OW = 2*W+2;
  localparam int SH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_i = '0, in_q = '0;
  logic out_valid, out_valid_s;
  logic [OW-1:0] out_z, out_z_s;

  always #4 clk = ~clk;

  fm_xprod_discrim #(.W(W), .SHIFT(0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_z(out_z));
  fm_xprod_discrim #(.W(W), .SHIFT(SH)) uut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid_s), .out_z(out_z_s));

  int checks = 0, fails = 0;
  longint cyc = 0;
  bit done = 0;
  longint exp_z[$], exp_c[$];
  int exp_sign[$];
  string exp_tag[$];
  longint bi = 0, bq = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(int i, int q, string tag, int sgn);
    longint z;
    @(negedge clk);
    z = longint'(i) * (longint'(q) - bq) - longint'(q) * (longint'(i) - bi);
    exp_z.push_back(z);
    exp_c.push_back(cyc + 2);
    exp_sign.push_back(sgn);
    exp_tag.push_back(tag);
    bi = i; bq = q;
    in_valid = 1'b1;
    in_i = W'(i);
    in_q = W'(q);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_i = W'($urandom);
      in_q = W'($urandom);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid != out_valid_s) check(0, "R4 instances disagree", out_valid_s, out_valid);
      if (out_valid) begin
        if (exp_z.size() == 0) check(0, "R4 unexpected out_valid", 1, 0);
        else begin
          longint e, g, gs, c;
          int s;
          string t;
          e = exp_z.pop_front(); c = exp_c.pop_front();
          s = exp_sign.pop_front(); t = exp_tag.pop_front();
          g = longint'($signed(out_z));
          gs = longint'($signed(out_z_s));
          check(cyc == c, {t, " R4 latency"}, cyc, c);
          check(g == e, {t, " R3 value"}, g, e);
          check(gs == (e >>> SH), {t, " R8 shifted"}, gs, e >>> SH);
          if (s > 0) check(g > 0, {t, " R6 ccw positive"}, g, 1);
          if (s < 0) check(g < 0, {t, " R6 cw negative"}, g, -1);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ang;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 valid in reset", out_valid, 0);
    check(out_z == 0, "R1 z in reset", longint'($signed(out_z)), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    check(out_valid == 0, "R1 valid after reset", out_valid, 0);
    check(out_z == 0, "R1 z after reset", longint'($signed(out_z)), 0);

    send(12345, -23456, "R2 first", 0);
    idle(4);
    check(out_z == 0, "R2 first zero", longint'($signed(out_z)), 0);

    send(-7, 3, "R5 gap", 0);
    idle(7);
    check(longint'($signed(out_z)) == exp_last(), "R5 hold", longint'($signed(out_z)), exp_last());
    send(100, 200, "R5 after gap", 0);
    idle(3);

    for (int k = 0; k < 16; k++) begin
      ang = k % 8;
      send(circ_i(ang), circ_q(ang), "R6 ccw", k == 0 ? 0 : 1);
    end
    for (int k = 0; k < 16; k++) begin
      ang = (8 - (k % 8)) % 8;
      send(circ_i(ang), circ_q(ang), "R6 cw", k == 0 ? 0 : -1);
    end
    idle(3);

    send(32767, -32768, "R7 corner", 0);
    send(-32768, -32768, "R7 corner", 0);
    send(-32768, 32767, "R7 corner", 0);
    send(32767, 32767, "R7 corner", 0);
    send(-32768, -32768, "R7 corner", 0);
    send(-1, 1, "R8 small neg", 0);
    send(1, 1, "R8 small neg", 0);
    idle(3);

    for (int k = 0; k < 300; k++) begin
      send(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R9 stream", 0);
      if (k % 37 == 0) idle(k % 5);
    end
    idle(5);
    check(exp_z.size() == 0, "R4 outputs missing", exp_z.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  longint last_seen = 0;
  always @(negedge clk) if (out_valid) last_seen = longint'($signed(out_z));
  function automatic longint exp_last();
    return last_seen;
  endfunction

  function automatic int circ_i(int a);
    case (a)
      0: return 10000; 1: return 7071; 2: return 0; 3: return -7071;
      4: return -10000; 5: return -7071; 6: return 0; default: return 7071;
    endcase
  endfunction
  function automatic int circ_q(int a);
    return circ_i((a + 6) % 8);
  endfunction
endmodule